// File: doc/BRIEF.md
# Two-Register Cartridge Bank Mapper

This block sits between an 8-bit CPU bus, a video bus and the two ROMs of a cartridge. It translates addresses. A CPU address in the 32 KB program area becomes a program-ROM byte address. A video address in the 8 KB pattern area becomes a character-ROM byte address. Each translation takes a coarse (outer) bank and a fine (inner) bank. These live in two separately addressed registers.

A CPU write anywhere in the 0x6000–0x7FFF window loads both outer banks. A CPU write anywhere in 0x8000–0xFFFF loads both inner banks. The inner banks sit at unusual data bit positions. Both translated addresses follow the current register contents combinationally.

The ROM sizes are configuration inputs, and page numbers wrap at those sizes. The nametable mirroring output is a constant that is picked by parameter and applied at reset.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is low, and after it is released, all four bank fields read as zero. Slot k of either area then maps to page k, wrapped by ROM size.
- R2: A strobed write with CPU address in 0x6000–0x7FFF loads the outer program bank from data bits 3:0 and the outer character bank from data bits 7:4.
- R3: A strobed write with CPU address in 0x8000–0xFFFF has three effects. It loads the inner program bank from data bit 0. It loads the inner character bank from data bits 6:4. It leaves both outer banks unchanged. Data bits 3:1 and 7 of such a write have no effect.
- R4: A write strobe with an address below 0x6000 changes no bank field. Bus activity in either window without the strobe also changes no bank field.
- R5: The program page is outer_prg·8 + inner_prg·4 + k, where k is CPU address bits 14:13. The program byte address is page·8192 + CPU address bits 12:0. CPU address bit 15 does not enter the translation.
- R6: The character page is outer_chr·64 + inner_chr·8 + k, where k is video address bits 12:10. The character byte address is page·1024 + video address bits 9:0.
- R7: The program page wraps modulo 2·prg_units_i, the program-ROM size in 8 KB pages. The unit count must be a power of two.
- R8: The character page wraps modulo 8·chr_units_i, the character-ROM size in 1 KB pages. The unit count must be a power of two.
- R9: mirror_vert_o equals the MIRROR_VERT parameter from reset onward. No register write changes it.
- R10: A write takes effect at the clock edge where the strobe is sampled high. Before that edge, the translated addresses still follow the old banks. After it, they follow the new banks with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| vid_addr_i | input | 13 | Video pattern-area address |
| prg_units_i | input | 8 | Program-ROM size in 16 KB units (power of two) |
| chr_units_i | input | 8 | Character-ROM size in 8 KB units (power of two) |
| prg_addr_o | output | 20 | Program-ROM byte address |
| chr_addr_o | output | 20 | Character-ROM byte address |
| mirror_vert_o | output | 1 | Fixed nametable mirroring mode (1 = vertical) |

## Verification
The outer register is swept through all 256 data values. Each value is combined with four inner-register values chosen to set and clear both inner fields while also toggling the data bits that must be ignored, which separates R2 from R3. The sweep is repeated for five ROM size pairs, running from a single unit (heavy wrapping) up to sizes that hold every reachable page (no wrapping). This shows that the wrap follows the configured size and not a fixed mask.

After each write, all eight character slots and all four program slots are read back, with CPU bit 15 toggled. This catches swapped slot bits or a wrong offset splice. Writes below 0x6000 and unstrobed window traffic must leave every slot unchanged. One write is also sampled before and after its clock edge to fix the update cycle.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  // bus widths
  localparam int CPU_AW      = 16;
  localparam int DATA_W      = 8;
  localparam int VID_AW      = 13;

  // program side geometry: 8 KB pages, four slots
  localparam int PRG_OFFS_W  = 13;
  localparam int PRG_SLOT_W  = 2;
  localparam int PRG_OUTER_W = 4;
  localparam int PRG_INNER_W = 1;

  // character side geometry: 1 KB pages, eight slots
  localparam int CHR_OFFS_W  = 10;
  localparam int CHR_SLOT_W  = 3;
  localparam int CHR_OUTER_W = 4;
  localparam int CHR_INNER_W = 3;

  // data bit positions of each field (the software contract)
  localparam int PRG_OUTER_LSB = 0;
  localparam int CHR_OUTER_LSB = 4;
  localparam int PRG_INNER_LSB = 0;
  localparam int CHR_INNER_LSB = 4;

  // size units expressed as log2 of pages per unit
  localparam int PRG_UNIT_SHIFT = 1;
  localparam int CHR_UNIT_SHIFT = 3;

  localparam int PRG_PAGE_W = PRG_OUTER_W + PRG_INNER_W + PRG_SLOT_W;
  localparam int CHR_PAGE_W = CHR_OUTER_W + CHR_INNER_W + CHR_SLOT_W;
  localparam int PRG_ADDR_W = PRG_PAGE_W + PRG_OFFS_W;
  localparam int CHR_ADDR_W = CHR_PAGE_W + CHR_OFFS_W;

  typedef struct packed {
    logic [PRG_OUTER_W-1:0] prg_outer;
    logic [CHR_OUTER_W-1:0] chr_outer;
    logic [PRG_INNER_W-1:0] prg_inner;
    logic [CHR_INNER_W-1:0] chr_inner;
  } bank_state_t;

endpackage

// File: rtl/cart_bus_decode.sv
module cart_bus_decode
  import cart_map_pkg::*;
(
  input  logic              wr_i,
  input  logic [CPU_AW-1:0] addr_i,
  output logic              outer_we_o,
  output logic              inner_we_o
);

  // outer window: 0x6000-0x7FFF, inner window: 0x8000-0xFFFF
  localparam logic [2:0] OUTER_TAG = 3'b011;

  logic in_outer;
  logic in_inner;

  always_comb begin
    in_outer   = (addr_i[CPU_AW-1 -: 3] == OUTER_TAG);
    in_inner   = addr_i[CPU_AW-1];
    outer_we_o = wr_i && in_outer;
    inner_we_o = wr_i && in_inner;
  end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_map_pkg::*;
#(
  parameter logic MIRROR_VERT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              outer_we_i,
  input  logic              inner_we_i,
  input  logic [DATA_W-1:0] data_i,
  output bank_state_t       bank_o,
  output logic              mirror_o
);

  bank_state_t bank_d;
  bank_state_t bank_q;
  logic        bank_en;
  logic        mirror_q;

  // next-state
  always_comb begin
    bank_d  = bank_q;
    bank_en = outer_we_i || inner_we_i;
    if (outer_we_i) begin
      bank_d.prg_outer = data_i[PRG_OUTER_LSB +: PRG_OUTER_W];
      bank_d.chr_outer = data_i[CHR_OUTER_LSB +: CHR_OUTER_W];
    end
    if (inner_we_i) begin
      bank_d.prg_inner = data_i[PRG_INNER_LSB +: PRG_INNER_W];
      bank_d.chr_inner = data_i[CHR_INNER_LSB +: CHR_INNER_W];
    end
  end

  // state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_d;
    end
  end

  // mirroring mode: loaded from the parameter at reset, then held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mirror_q <= MIRROR_VERT;
    end else begin
      mirror_q <= mirror_q;
    end
  end

  assign bank_o   = bank_q;
  assign mirror_o = mirror_q;

endmodule

// File: rtl/cart_page_xlate.sv
module cart_page_xlate #(
  parameter int OUTER_W    = 4,
  parameter int INNER_W    = 1,
  parameter int SLOT_W     = 2,
  parameter int OFFS_W     = 13,
  parameter int SIZE_W     = 8,
  parameter int UNIT_SHIFT = 1,
  localparam int PAGE_W    = OUTER_W + INNER_W + SLOT_W,
  localparam int BUS_W     = SLOT_W + OFFS_W,
  localparam int ROM_W     = PAGE_W + OFFS_W
) (
  input  logic [OUTER_W-1:0] outer_i,
  input  logic [INNER_W-1:0] inner_i,
  input  logic [BUS_W-1:0]   bus_addr_i,
  input  logic [SIZE_W-1:0]  units_i,
  output logic [ROM_W-1:0]   rom_addr_o
);

  localparam int EXT_W = SIZE_W + UNIT_SHIFT;
  localparam int MW    = (EXT_W > PAGE_W) ? EXT_W : PAGE_W;

  logic [PAGE_W-1:0] page_raw;
  logic [MW-1:0]     size_pages;
  logic [MW-1:0]     page_mask;
  logic [MW-1:0]     page_wrap;

  always_comb begin
    // outer*2^(INNER+SLOT) + inner*2^SLOT + slot is a plain splice
    page_raw   = {outer_i, inner_i, bus_addr_i[BUS_W-1 -: SLOT_W]};
    size_pages = MW'(units_i) << UNIT_SHIFT;
    page_mask  = size_pages - MW'(1);
    page_wrap  = MW'(page_raw) & page_mask;
    rom_addr_o = {page_wrap[PAGE_W-1:0], bus_addr_i[OFFS_W-1:0]};
  end

  generate
    if (MW > PAGE_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^page_wrap[MW-1:PAGE_W];
    end
  endgenerate

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int   SIZE_W      = 8,
  parameter logic MIRROR_VERT = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cpu_wr_i,
  input  logic [CPU_AW-1:0]     cpu_addr_i,
  input  logic [DATA_W-1:0]     cpu_data_i,
  input  logic [VID_AW-1:0]     vid_addr_i,
  input  logic [SIZE_W-1:0]     prg_units_i,
  input  logic [SIZE_W-1:0]     chr_units_i,
  output logic [PRG_ADDR_W-1:0] prg_addr_o,
  output logic [CHR_ADDR_W-1:0] chr_addr_o,
  output logic                  mirror_vert_o
);

  localparam int PRG_BUS_W = PRG_SLOT_W + PRG_OFFS_W;

  logic        outer_we;
  logic        inner_we;
  bank_state_t bank_q;

  cart_bus_decode u_decode (
    .wr_i       (cpu_wr_i),
    .addr_i     (cpu_addr_i),
    .outer_we_o (outer_we),
    .inner_we_o (inner_we)
  );

  cart_bank_regs #(
    .MIRROR_VERT (MIRROR_VERT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .outer_we_i (outer_we),
    .inner_we_i (inner_we),
    .data_i     (cpu_data_i),
    .bank_o     (bank_q),
    .mirror_o   (mirror_vert_o)
  );

  cart_page_xlate #(
    .OUTER_W    (PRG_OUTER_W),
    .INNER_W    (PRG_INNER_W),
    .SLOT_W     (PRG_SLOT_W),
    .OFFS_W     (PRG_OFFS_W),
    .SIZE_W     (SIZE_W),
    .UNIT_SHIFT (PRG_UNIT_SHIFT)
  ) u_prg (
    .outer_i    (bank_q.prg_outer),
    .inner_i    (bank_q.prg_inner),
    .bus_addr_i (cpu_addr_i[PRG_BUS_W-1:0]),
    .units_i    (prg_units_i),
    .rom_addr_o (prg_addr_o)
  );

  cart_page_xlate #(
    .OUTER_W    (CHR_OUTER_W),
    .INNER_W    (CHR_INNER_W),
    .SLOT_W     (CHR_SLOT_W),
    .OFFS_W     (CHR_OFFS_W),
    .SIZE_W     (SIZE_W),
    .UNIT_SHIFT (CHR_UNIT_SHIFT)
  ) u_chr (
    .outer_i    (bank_q.chr_outer),
    .inner_i    (bank_q.chr_inner),
    .bus_addr_i (vid_addr_i),
    .units_i    (chr_units_i),
    .rom_addr_o (chr_addr_o)
  );

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cart_map_pkg::*;
#(
  parameter int   SIZE_W      = 8,
  parameter logic MIRROR_VERT = 1'b1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_wr_i,
  input logic [CPU_AW-1:0]     cpu_addr_i,
  input logic [DATA_W-1:0]     cpu_data_i,
  input logic [VID_AW-1:0]     vid_addr_i,
  input logic [SIZE_W-1:0]     prg_units_i,
  input logic [SIZE_W-1:0]     chr_units_i,
  input logic [PRG_ADDR_W-1:0] prg_addr_o,
  input logic [CHR_ADDR_W-1:0] chr_addr_o,
  input logic                  mirror_vert_o,
  input bank_state_t           bank_q
);

  logic hit_outer;
  logic hit_inner;
  assign hit_outer = cpu_wr_i && (cpu_addr_i[15:13] == 3'b011);
  assign hit_inner = cpu_wr_i && cpu_addr_i[15];

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (bank_q == '0));

  // R2
  outer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_outer |=> (bank_q.prg_outer == $past(cpu_data_i[3:0])) &&
                  (bank_q.chr_outer == $past(cpu_data_i[7:4])));

  // R3
  inner_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_inner |=> (bank_q.prg_inner == $past(cpu_data_i[0])) &&
                  (bank_q.chr_inner == $past(cpu_data_i[6:4])) &&
                  $stable(bank_q.prg_outer) && $stable(bank_q.chr_outer));

  // R4
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_outer || hit_inner) |=> $stable(bank_q));

  // R5
  prg_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_addr_o[PRG_OFFS_W-1:0] == cpu_addr_i[PRG_OFFS_W-1:0]);

  // R6
  chr_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[CHR_OFFS_W-1:0] == vid_addr_i[CHR_OFFS_W-1:0]);

  // R7
  prg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(prg_units_i) == 1) |->
      (32'(prg_addr_o[PRG_ADDR_W-1:PRG_OFFS_W]) < (32'(prg_units_i) << PRG_UNIT_SHIFT)));

  // R8
  chr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(chr_units_i) == 1) |->
      (32'(chr_addr_o[CHR_ADDR_W-1:CHR_OFFS_W]) < (32'(chr_units_i) << CHR_UNIT_SHIFT)));

  // R9
  mirror_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_vert_o == MIRROR_VERT);

endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(
  .SIZE_W      (SIZE_W),
  .MIRROR_VERT (MIRROR_VERT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_wr_i      (cpu_wr_i),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_data_i    (cpu_data_i),
  .vid_addr_i    (vid_addr_i),
  .prg_units_i   (prg_units_i),
  .chr_units_i   (chr_units_i),
  .prg_addr_o    (prg_addr_o),
  .chr_addr_o    (chr_addr_o),
  .mirror_vert_o (mirror_vert_o),
  .bank_q        (bank_q)
);

// File: tb/cart_bank_mapper_test.sv
`timescale 1ns/1ps
module cart_bank_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic [12:0] vid_addr;
  logic [7:0]  prg_units;
  logic [7:0]  chr_units;
  logic [19:0] prg_addr;
  logic [19:0] chr_addr;
  logic        mirror_vert;

  int checks = 0;
  int errors = 0;
  int m_po = 0, m_pc = 0, m_ip = 0, m_ic = 0;

  always #5 clk = ~clk;

  cart_bank_mapper uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cpu_wr_i      (cpu_wr),
    .cpu_addr_i    (cpu_addr),
    .cpu_data_i    (cpu_data),
    .vid_addr_i    (vid_addr),
    .prg_units_i   (prg_units),
    .chr_units_i   (chr_units),
    .prg_addr_o    (prg_addr),
    .chr_addr_o    (chr_addr),
    .mirror_vert_o (mirror_vert)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_prg(int slot, int off);
    int page;
    page = (m_po * 8 + m_ip * 4 + slot) % (int'(prg_units) * 2);
    return page * 8192 + off;
  endfunction

  function automatic int exp_chr(int slot, int off);
    int page;
    page = (m_pc * 64 + m_ic * 8 + slot) % (int'(chr_units) * 8);
    return page * 1024 + off;
  endfunction

  task automatic bus_cycle(logic [15:0] a, logic [7:0] d, logic strobe);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr   = strobe;
    @(negedge clk);
    cpu_wr   = 1'b0;
  endtask

  task automatic write_outer(logic [15:0] a, logic [7:0] d);
    bus_cycle(a, d, 1'b1);
    m_po = int'(d[3:0]);
    m_pc = int'(d[7:4]);
  endtask

  task automatic write_inner(logic [15:0] a, logic [7:0] d);
    bus_cycle(a, d, 1'b1);
    m_ip = int'(d[0]);
    m_ic = int'(d[6:4]);
  endtask

  // read every slot of both areas against the model
  task automatic verify(string tag);
    string pr, cr;
    pr = ((m_po * 8 + m_ip * 4 + 3) >= int'(prg_units) * 2) ? "R7" : "R5";
    cr = ((m_pc * 64 + m_ic * 8 + 7) >= int'(chr_units) * 8) ? "R8" : "R6";
    for (int k = 0; k < 8; k++) begin
      int poff, coff;
      poff = (13'h1555 ^ k) & 16'h1FFF;
      coff = (10'h3A5 ^ (k * 37)) & 10'h3FF;
      @(negedge clk);
      cpu_addr = 16'(((k / 4) << 15) | ((k % 4) << 13) | poff);
      vid_addr = 13'((k << 10) | coff);
      #1;
      check({tag, " ", pr, " prg"}, 32'(prg_addr), 32'(exp_prg(k % 4, poff)));
      check({tag, " ", cr, " chr"}, 32'(chr_addr), 32'(exp_chr(k, coff)));
    end
  endtask

  logic [7:0] inner_set [4] = '{8'h00, 8'h01, 8'h71, 8'hFE};
  logic [15:0] inner_adr [4] = '{16'h8000, 16'hFFFF, 16'hC3A1, 16'hA000};
  logic [7:0] pu_set [5] = '{8'd1, 8'd2, 8'd4, 8'd16, 8'd64};
  logic [7:0] cu_set [5] = '{8'd1, 8'd2, 8'd8, 8'd32, 8'd128};

  initial begin
    rst_n     = 1'b0;
    cpu_wr    = 1'b0;
    cpu_addr  = 16'h8000;
    cpu_data  = 8'h00;
    vid_addr  = 13'h0000;
    prg_units = 8'd8;
    chr_units = 8'd16;
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset: page 0 in slot 0
    check("R1 prg in reset", 32'(prg_addr), 32'h0);
    check("R1 chr in reset", 32'(chr_addr), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    verify("R1");
    // R9
    check("R9 mirror after reset", 32'(mirror_vert), 32'h1);

    // R10: old value before the edge, new one right after
    write_outer(16'h6000, 8'h21);
    @(negedge clk);
    cpu_addr = 16'h6000;
    cpu_data = 8'h53;
    cpu_wr   = 1'b1;
    vid_addr = 13'h0000;
    #1;
    check("R10 before edge", 32'(chr_addr), 32'(exp_chr(0, 0)));
    @(negedge clk);
    cpu_wr = 1'b0;
    m_po = 3;
    m_pc = 5;
    vid_addr = 13'h0000;
    #1;
    check("R10 after edge", 32'(chr_addr), 32'(exp_chr(0, 0)));

    // R4: no-strobe and out-of-window traffic is ignored
    write_outer(16'h7123, 8'h5A);
    write_inner(16'h8001, 8'h31);
    bus_cycle(16'h5FFF, 8'hFF, 1'b1);
    bus_cycle(16'h4020, 8'hA5, 1'b1);
    bus_cycle(16'h0000, 8'hC3, 1'b1);
    bus_cycle(16'h6000, 8'hFF, 1'b0);
    bus_cycle(16'h9000, 8'h00, 1'b0);
    verify("R4");

    // R2 R3 sweep over sizes, outer values and inner values
    for (int s = 0; s < 5; s++) begin
      @(negedge clk);
      prg_units = pu_set[s];
      chr_units = cu_set[s];
      for (int d = 0; d < 256; d++) begin
        write_outer(((d % 2) != 0) ? 16'h7FFF : 16'h6000, 8'(d));
        for (int i = 0; i < 4; i++) begin
          write_inner(inner_adr[i], inner_set[i]);
          verify((i == 0) ? "R2" : "R3");
        end
      end
    end

    // R9 after all writes
    check("R9 mirror after writes", 32'(mirror_vert), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule